// File: doc/BRIEF.md
# Bytecode Execution State Controller

This block owns the two status-word bits that select among three instruction-set states: native, compressed, and a bytecode state in which stack-machine bytecodes are run directly. It holds two writable configuration registers and a fixed identity word. These are reached through a small coprocessor-style port that checks the caller's privilege. It settles every branch-and-exchange request. The request enters the bytecode state only when the operating system has marked the setup valid and the enable bit is on. Otherwise it behaves as an ordinary register branch.

While the core is in the bytecode state, each offered bytecode is sorted into one of three outcomes. A hardware-supported opcode is executed in hardware. An unsupported opcode is sent to a software handler at a computed vector. An illegal opcode or the breakpoint code starts an exception. Each change of state costs a fixed busy window, and no bytecodes are accepted during it. The bit pair in force when an exception is taken is saved and put back on return, so the bytecode state survives interrupts. A build parameter reduces the block to a plain branch unit whose configuration reads all return zero.

Top module: `bcx_state_ctrl`

## Requirements
- R1: After reset, st_t, st_j, saved_t, saved_j, busy, bc_hw, bc_sw, bc_exc and cfg_fault are all 0. A kernel read of the OS control register (cfg_sel=1) or the main configuration register (cfg_sel=2) returns 0.
- R2: A br_req is seen on the cycle after the request. If bit 0 of the main configuration register and bit 1 of the OS control register are both 1, the result is st_j=1, st_t=0 and br_pc=lr_val. Otherwise the result is st_j=0, st_t=br_target[0] and br_pc=br_target with bit 0 cleared. br_pc_vld is 1 for that cycle in both cases, and st_t and st_j are never both 1.
- R3: The identity register (cfg_sel=0) reads as ID_VALUE in both privilege modes without a fault, and writes to it change nothing.
- R4: The OS control register (cfg_sel=1) can be read and written in kernel mode (cfg_kernel=1). Any user-mode access to it sets cfg_fault for one cycle, returns 0 and leaves the register unchanged.
- R5: The main configuration register (cfg_sel=2) accepts writes in both modes. A user-mode read returns 0 without a fault, and a kernel read returns the stored value.
- R6: In the bytecode state with busy low, a bc_valid opcode gives exactly one one-cycle pulse on the next cycle. With the default table, codes 0x00 to 0x7F give bc_hw. Codes 0x80 to 0xC9 give bc_sw, with bc_vec = HANDLER_BASE + 4*opcode.
- R7: Opcode 0xFF, and any opcode at or above ILLEGAL_FIRST (0xCA), gives bc_exc. The state falls to native, and saved_j=1, saved_t=0.
- R8: Every change of {st_t,st_j} holds busy at 1 for the next 4 sampled cycles. A bytecode offered while busy is 1, or outside the bytecode state, produces no dispatch pulse.
- R9: exc_take copies {st_t,st_j} into {saved_t,saved_j} and forces the native state. exc_ret restores the saved pair. Exception entry wins over return, and return wins over a branch. A bytecode offered in the same cycle as exc_take is dropped.
- R10: With MINIMAL=1, every configuration read returns 0 and a branch never sets st_j.
- R11: Configuration read data and the fault flag appear on the cycle after cfg_req. An unused select (cfg_sel=3) reads 0 without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_kernel | input | 1 | Caller is in kernel mode |
| cfg_sel | input | 2 | 0 identity, 1 OS control, 2 main configuration |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after the request |
| cfg_fault | output | 1 | Access exception, one cycle after the request |
| br_req | input | 1 | Branch-to-bytecode request |
| br_target | input | 32 | Register target of the fallback branch |
| lr_val | input | 32 | Link register value, the next bytecode address |
| br_pc | output | 32 | Resolved branch address |
| br_pc_vld | output | 1 | br_pc is valid |
| exc_take | input | 1 | External exception entry |
| exc_ret | input | 1 | Return from exception |
| bc_valid | input | 1 | Bytecode offered |
| bc_op | input | 8 | Bytecode value |
| bc_hw | output | 1 | Executed in hardware |
| bc_sw | output | 1 | Sent to software handler |
| bc_exc | output | 1 | Illegal or breakpoint exception |
| bc_vec | output | 32 | Handler vector when bc_sw is 1, else 0 |
| st_t | output | 1 | Compressed-state bit |
| st_j | output | 1 | Bytecode-state bit |
| saved_t | output | 1 | Saved compressed bit |
| saved_j | output | 1 | Saved bytecode bit |
| busy | output | 1 | State-switch window in progress |

## Verification
A corrupted enable or valid bit shows up on the first branch after the corruption: the state bits and br_pc then take the wrong path one cycle after the request. A wrong busy count appears as a bytecode that is accepted or dropped one cycle early or late, visible at the dispatch pulses. A lost saved pair shows up on the first exception return, when st_j comes back with the wrong value. A wrong table entry or breakpoint decode shows up on the cycle after that opcode is offered.

// File: rtl/bcx_state_ctrl.sv
module bcx_state_ctrl #(
  parameter logic [31:0]  ID_VALUE      = 32'h7400_0001,
  parameter logic [31:0]  HANDLER_BASE  = 32'h0000_4000,
  parameter logic [255:0] HW_MAP        = {{128{1'b0}}, {128{1'b1}}},
  parameter logic [7:0]   ILLEGAL_FIRST = 8'hCA,
  parameter int           SWITCH_CYCLES = 4,
  parameter bit           MINIMAL       = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_req,
  input  logic        cfg_wr,
  input  logic        cfg_kernel,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_fault,
  input  logic        br_req,
  input  logic [31:0] br_target,
  input  logic [31:0] lr_val,
  output logic [31:0] br_pc,
  output logic        br_pc_vld,
  input  logic        exc_take,
  input  logic        exc_ret,
  input  logic        bc_valid,
  input  logic [7:0]  bc_op,
  output logic        bc_hw,
  output logic        bc_sw,
  output logic        bc_exc,
  output logic [31:0] bc_vec,
  output logic        st_t,
  output logic        st_j,
  output logic        saved_t,
  output logic        saved_j,
  output logic        busy
);
  localparam int         CW       = $clog2(SWITCH_CYCLES + 1);
  localparam logic [1:0] SEL_ID   = 2'd0;
  localparam logic [1:0] SEL_OS   = 2'd1;
  localparam logic [1:0] SEL_MAIN = 2'd2;

  logic [31:0]   os_reg, main_reg, rd_nxt;
  logic [CW-1:0] busy_cnt;
  logic          nxt_t, nxt_j;

  wire bc_take    = bc_valid && st_j && (busy_cnt == '0) && !exc_take;
  wire bc_illegal = (bc_op == 8'hFF) || (bc_op >= ILLEGAL_FIRST);
  wire bc_native  = HW_MAP[bc_op];
  wire enter_exc  = exc_take || (bc_take && bc_illegal);
  wire jump_ok    = !MINIMAL && main_reg[0] && os_reg[1];
  wire user_os    = cfg_req && !cfg_kernel && (cfg_sel == SEL_OS);
  wire wr_os      = cfg_req && cfg_wr && cfg_kernel && (cfg_sel == SEL_OS);
  wire wr_main    = cfg_req && cfg_wr && (cfg_sel == SEL_MAIN);
  wire br_go      = br_req && !enter_exc && !exc_ret;

  assign busy = (busy_cnt != '0);

  always_comb begin
    rd_nxt = '0;
    if (cfg_req && !cfg_wr && !MINIMAL) begin
      case (cfg_sel)
        SEL_ID:   rd_nxt = ID_VALUE;
        SEL_OS:   rd_nxt = cfg_kernel ? os_reg : '0;
        SEL_MAIN: rd_nxt = cfg_kernel ? main_reg : '0;
        default:  rd_nxt = '0;
      endcase
    end
  end

  always_comb begin
    nxt_t = st_t;
    nxt_j = st_j;
    if (enter_exc) begin
      nxt_t = 1'b0;
      nxt_j = 1'b0;
    end else if (exc_ret) begin
      nxt_t = saved_t;
      nxt_j = saved_j;
    end else if (br_req) begin
      nxt_t = jump_ok ? 1'b0 : br_target[0];
      nxt_j = jump_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      os_reg    <= '0;
      main_reg  <= '0;
      cfg_rdata <= '0;
      cfg_fault <= 1'b0;
      st_t      <= 1'b0;
      st_j      <= 1'b0;
      saved_t   <= 1'b0;
      saved_j   <= 1'b0;
      busy_cnt  <= '0;
      br_pc     <= '0;
      br_pc_vld <= 1'b0;
      bc_hw     <= 1'b0;
      bc_sw     <= 1'b0;
      bc_exc    <= 1'b0;
      bc_vec    <= '0;
    end else begin
      if (wr_os)   os_reg   <= cfg_wdata;
      if (wr_main) main_reg <= cfg_wdata;
      cfg_rdata <= rd_nxt;
      cfg_fault <= user_os;

      st_t <= nxt_t;
      st_j <= nxt_j;
      if (enter_exc) begin
        saved_t <= st_t;
        saved_j <= st_j;
      end
      if ({nxt_t, nxt_j} != {st_t, st_j}) busy_cnt <= CW'(SWITCH_CYCLES);
      else if (busy_cnt != '0)            busy_cnt <= busy_cnt - CW'(1);

      br_pc_vld <= br_go;
      br_pc     <= !br_go ? '0 : (jump_ok ? lr_val : {br_target[31:1], 1'b0});

      bc_hw  <= bc_take && !bc_illegal && bc_native;
      bc_sw  <= bc_take && !bc_illegal && !bc_native;
      bc_exc <= bc_take && bc_illegal;
      bc_vec <= (bc_take && !bc_illegal && !bc_native) ?
                HANDLER_BASE + {22'b0, bc_op, 2'b00} : '0;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_t && st_j)); // R2
  AST_J_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (br_go && !(main_reg[0] && os_reg[1])) |=> !st_j); // R2
  AST_J_ENTRY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_j) |-> $past(exc_ret || (br_req && main_reg[0] && os_reg[1]))); // R2
  AST_USER_OS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    user_os |=> (cfg_fault && cfg_rdata == '0)); // R4
  AST_USER_OS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    user_os |=> $stable(os_reg)); // R4
  AST_DISPATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bc_hw, bc_sw, bc_exc})); // R6
  AST_BREAK_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_op == 8'hFF && st_j && !busy && !exc_take) |=> bc_exc); // R7
  AST_NO_DISPATCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(bc_hw || bc_sw || bc_exc)); // R8
  AST_NATIVE_AFTER_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    enter_exc |=> (!st_t && !st_j)); // R9
  AST_MIN_NO_J: assert property (@(posedge clk) disable iff (!rst_n)
    MINIMAL |-> (!st_j && cfg_rdata == '0)); // R10
endmodule

// File: tb/bcx_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module bcx_state_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_req = 0, cfg_wr = 0, cfg_kernel = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        br_req = 0;
  logic [31:0] br_target = 0, lr_val = 0;
  logic        exc_take = 0, exc_ret = 0, bc_valid = 0;
  logic [7:0]  bc_op = 0;

  logic [31:0] cfg_rdata, br_pc, bc_vec;
  logic        cfg_fault, br_pc_vld, bc_hw, bc_sw, bc_exc, st_t, st_j, saved_t, saved_j, busy;
  logic [31:0] n_rdata, n_pc, n_vec;
  logic        n_fault, n_pcv, n_hw, n_sw, n_exc, n_t, n_j, n_svt, n_svj, n_busy;

  bcx_state_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_kernel(cfg_kernel),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_fault(cfg_fault),
    .br_req(br_req), .br_target(br_target), .lr_val(lr_val), .br_pc(br_pc), .br_pc_vld(br_pc_vld),
    .exc_take(exc_take), .exc_ret(exc_ret), .bc_valid(bc_valid), .bc_op(bc_op),
    .bc_hw(bc_hw), .bc_sw(bc_sw), .bc_exc(bc_exc), .bc_vec(bc_vec),
    .st_t(st_t), .st_j(st_j), .saved_t(saved_t), .saved_j(saved_j), .busy(busy));

  bcx_state_ctrl #(.MINIMAL(1'b1)) dut_min (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_kernel(cfg_kernel),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(n_rdata), .cfg_fault(n_fault),
    .br_req(br_req), .br_target(br_target), .lr_val(lr_val), .br_pc(n_pc), .br_pc_vld(n_pcv),
    .exc_take(exc_take), .exc_ret(exc_ret), .bc_valid(bc_valid), .bc_op(bc_op),
    .bc_hw(n_hw), .bc_sw(n_sw), .bc_exc(n_exc), .bc_vec(n_vec),
    .st_t(n_t), .st_j(n_j), .saved_t(n_svt), .saved_j(n_svj), .busy(n_busy));

  int vecs = 0, errs = 0;
  logic m_t = 0, m_j = 0, m_en = 0, m_vld = 0;
  localparam logic [31:0] ID_EXP = 32'h7400_0001;
  localparam logic [31:0] HBASE  = 32'h0000_4000;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int cls(input logic [7:0] op);
    if (op == 8'hFF || op >= 8'hCA) return 2;
    if (op < 8'h80) return 0;
    return 1;
  endfunction

  task automatic cfg(input logic wr, input logic kern, input logic [1:0] sel, input logic [31:0] d);
    cfg_req = 1; cfg_wr = wr; cfg_kernel = kern; cfg_sel = sel; cfg_wdata = d;
    tick();
    cfg_req = 0; cfg_wr = 0; cfg_kernel = 0; cfg_sel = 0; cfg_wdata = 0;
  endtask

  task automatic branch(input logic [31:0] tgt, input logic [31:0] lr);
    logic [31:0] epc;
    br_req = 1; br_target = tgt; lr_val = lr;
    tick();
    br_req = 0; br_target = 0; lr_val = 0;
    if (m_en && m_vld) begin m_t = 0; m_j = 1; epc = lr; end
    else begin m_t = tgt[0]; m_j = 0; epc = {tgt[31:1], 1'b0}; end
    chk("R2 st_j", 32'(st_j), 32'(m_j));
    chk("R2 st_t", 32'(st_t), 32'(m_t));
    chk("R2 br_pc", br_pc, epc);
    chk("R2 br_pc_vld", 32'(br_pc_vld), 32'd1);
  endtask

  task automatic settle(input logic expect_busy);
    chk("R8 busy first", 32'(busy), 32'(expect_busy));
    repeat (3) tick();
    chk("R8 busy held", 32'(busy), 32'(expect_busy));
    tick();
    chk("R8 busy end", 32'(busy), 32'd0);
  endtask

  task automatic bc(input logic [7:0] op, input logic acc);
    int c;
    bc_valid = 1; bc_op = op;
    tick();
    bc_valid = 0; bc_op = 0;
    c = acc ? cls(op) : 3;
    chk("R6 hw", 32'(bc_hw), 32'(c == 0));
    chk("R6 sw", 32'(bc_sw), 32'(c == 1));
    chk("R6 vec", bc_vec, (c == 1) ? HBASE + {22'b0, op, 2'b00} : 32'h0);
    chk("R7 exc", 32'(bc_exc), 32'(c == 2));
    if (c == 2) begin
      m_t = 0; m_j = 0;
      chk("R7 native", 32'({st_t, st_j}), 32'd0);
      chk("R7 saved_j", 32'({saved_t, saved_j}), 32'd1);
    end
  endtask

  task automatic do_return();
    exc_ret = 1;
    tick();
    exc_ret = 0;
    m_j = 1; m_t = 0;
    chk("R9 restore", 32'({st_t, st_j}), 32'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'd1234));
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 state", 32'({st_t, st_j, saved_t, saved_j}), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 dispatch", 32'({bc_hw, bc_sw, bc_exc, cfg_fault}), 32'd0);
    cfg(0, 1, 2'd1, 0); chk("R1 os reset", cfg_rdata, 0);
    cfg(0, 1, 2'd2, 0); chk("R1 main reset", cfg_rdata, 0);

    cfg(0, 0, 2'd0, 0); chk("R3 id user", cfg_rdata, ID_EXP); chk("R3 id fault", 32'(cfg_fault), 0);
    chk("R10 min id", n_rdata, 0);
    cfg(1, 1, 2'd0, 32'hDEAD_BEEF);
    cfg(0, 1, 2'd0, 0); chk("R3 id kernel", cfg_rdata, ID_EXP);
    cfg(0, 1, 2'd3, 0); chk("R11 unused sel", cfg_rdata, 0); chk("R11 unused fault", 32'(cfg_fault), 0);

    cfg(0, 0, 2'd1, 0); chk("R4 user read fault", 32'(cfg_fault), 1); chk("R4 user read data", cfg_rdata, 0);
    cfg(1, 0, 2'd1, 32'h2); chk("R4 user write fault", 32'(cfg_fault), 1);
    tick(); chk("R4 fault one cycle", 32'(cfg_fault), 0);
    cfg(0, 1, 2'd1, 0); chk("R4 os unchanged", cfg_rdata, 0);

    branch(32'h0000_1001, 32'h0000_0500); settle(1);
    branch(32'h0000_2000, 32'h0000_0500); settle(1);
    bc(8'h10, 0);

    cfg(1, 0, 2'd2, 32'h1); chk("R5 user write no fault", 32'(cfg_fault), 0); m_en = 1;
    cfg(0, 0, 2'd2, 0); chk("R5 user read zero", cfg_rdata, 0); chk("R5 user read no fault", 32'(cfg_fault), 0);
    cfg(0, 1, 2'd2, 0); chk("R5 kernel read", cfg_rdata, 32'h1);
    branch(32'h0000_2000, 32'h0000_0700); chk("R8 no change no busy", 32'(busy), 0);

    cfg(1, 1, 2'd1, 32'h2); m_vld = 1;
    cfg(0, 1, 2'd1, 0); chk("R4 kernel rw", cfg_rdata, 32'h2);
    chk("R10 min os read", n_rdata, 0);
    branch(32'h0000_3001, 32'h0000_8000);
    chk("R10 min no j", 32'(n_j), 0); chk("R10 min t", 32'(n_t), 1);
    bc(8'h10, 0);
    tick(); tick();
    chk("R8 busy last", 32'(busy), 1);
    tick(); chk("R8 busy over", 32'(busy), 0);

    bc(8'h00, 1); bc(8'h7F, 1); bc(8'h80, 1); bc(8'hC9, 1);
    bc(8'hCA, 1); settle(1); do_return(); settle(1);
    bc(8'hFF, 1); settle(1); do_return(); settle(1);

    for (int i = 0; i < 80; i++) begin
      op = 8'($urandom);
      bc(op, 1);
      if (cls(op) == 2) begin settle(1); do_return(); settle(1); end
    end

    bc_valid = 1; bc_op = 8'h05; exc_take = 1;
    tick();
    bc_valid = 0; bc_op = 0; exc_take = 0;
    chk("R9 dropped", 32'({bc_hw, bc_sw, bc_exc}), 0);
    chk("R9 native", 32'({st_t, st_j}), 0);
    chk("R9 saved", 32'({saved_t, saved_j}), 32'b01);
    m_j = 0;
    settle(1);

    exc_take = 1; exc_ret = 1; br_req = 1; br_target = 32'h1;
    tick();
    exc_take = 0; exc_ret = 0; br_req = 0; br_target = 0;
    chk("R9 entry wins", 32'({st_t, st_j}), 0);
    chk("R9 saved native", 32'({saved_t, saved_j}), 0);
    chk("R9 no branch", 32'(br_pc_vld), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule